// File: doc/BRIEF.md
# Digital Potentiometer Quick-Command Controller

This block keeps the wiper code of each channel of a multi-channel digital potentiometer, together with a shadow copy that stands in for nonvolatile storage. A bus front end decodes a serial transaction and passes it in over a valid/ready handshake. The handshake carries a 4-bit command code, a 2-bit channel select, a command/register flag and one further address bit. The block then moves wiper codes up or down by one step or by a factor of two (6 dB), on one channel or on all of them. It can also copy a wiper into its shadow, copy a shadow back into its wiper, or reload every wiper from its shadow.

A store or a global reload starts a simulated nonvolatile write cycle that runs for a fixed number of clocks. During that cycle `busy` is high and `cmd_ready` is low, so the front end can refuse acknowledges while the host polls. An active-low write-protect pin freezes every wiper and shadow, and their read ports keep working. A restore raises a read-power flag, and the flag stays up until a no-op command is accepted.

Top module: `digpot_quick_ctrl`

## Requirements
- R1: After reset every wiper and every shadow hold the mid-scale value MID (default 128), `busy` and `read_pwr` are 0 and `cmd_ready` is 1.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. It is acted on only if `cmd_is_quick` is 1 and `cmd_a2` is 0. Any other accepted command changes no wiper or shadow and does not raise `busy`.
- R3: Code 1 copies the shadow of channel `cmd_chan` into its wiper and sets `read_pwr`. Only code 0 clears `read_pwr`. Other commands leave the flag as it is.
- R4: Code 2 copies the wiper of channel `cmd_chan` into its shadow. `busy` is then high, and `cmd_ready` low, for exactly WR_CYCLES clocks (default 16), starting with the clock after acceptance.
- R5: Code 7 copies every shadow into its wiper and starts the same busy window as R4.
- R6: Code 10 raises the addressed wiper by one and code 5 lowers it by one. Both saturate at 255 and at 0 and never wrap.
- R7: Code 8 doubles the addressed wiper. From 0 it goes to 1, and from any value of 128 or more it goes to 255. Code 3 halves the wiper, dropping the low bit.
- R8: Codes 11, 6, 9 and 4 apply the step-up, step-down, double and halve operations to every channel in the same clock.
- R9: Codes 12 to 15 change no wiper or shadow and do not raise `busy`.
- R10: While `wp_n` is 0 an accepted command changes no wiper or shadow and does not start a busy window. The read ports keep showing the stored values.
- R11: While `busy` is 1, no command is accepted and no wiper or shadow changes.
- R12: Channel i appears on bits [8*i+7 : 8*i] of `wiper_flat` and `shadow_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command (low while busy) |
| cmd_code | input | 4 | Quick-command code |
| cmd_chan | input | 2 | Addressed channel |
| cmd_is_quick | input | 1 | Command/register flag, 1 for a quick command |
| cmd_a2 | input | 1 | Upper address bit, must be 0 for a quick command |
| wp_n | input | 1 | Write protect, active low |
| busy | output | 1 | Nonvolatile write cycle in progress |
| read_pwr | output | 1 | Elevated-power read state after a restore |
| wiper_flat | output | 32 | All wiper codes, channel i at bits 8i+7:8i |
| shadow_flat | output | 32 | All shadow codes, same packing |

## Verification
The properties assume that reset is applied from time zero and that `cmd_code`, `cmd_chan`, `cmd_is_quick`, `cmd_a2` and `wp_n` hold steady across each clock edge at which `cmd_valid` is sampled. The bench keeps to this by changing every input only on the falling clock edge. Each command is held for exactly one rising edge. A command issued inside a busy window is presented on purpose, to confirm that the block refuses it. Write protect is changed only while no command is pending.

// File: rtl/digpot_pkg.sv
package digpot_pkg;

    // Quick-command codes; numeric values are fixed by the command set.
    typedef enum logic [3:0] {
        QC_NOP       = 4'd0,
        QC_RESTORE   = 4'd1,
        QC_STORE     = 4'd2,
        QC_HALVE_ONE = 4'd3,
        QC_HALVE_ALL = 4'd4,
        QC_DOWN_ONE  = 4'd5,
        QC_DOWN_ALL  = 4'd6,
        QC_RELOAD    = 4'd7,
        QC_DBL_ONE   = 4'd8,
        QC_DBL_ALL   = 4'd9,
        QC_UP_ONE    = 4'd10,
        QC_UP_ALL    = 4'd11
    } qcode_e;

    // Per-channel operation after decoding.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SAVE,
        OP_HALVE,
        OP_DOWN,
        OP_DBL,
        OP_UP
    } chan_op_e;

    typedef struct packed {
        logic     recog;    // quick command with a defined code
        logic     bcast;    // applies to every channel
        logic     nv_write; // starts a write cycle
        logic     is_nop;
        logic     is_restore;
        chan_op_e op;
    } qdec_t;

endpackage

// File: rtl/digpot_cmd_decode.sv
module digpot_cmd_decode
    import digpot_pkg::*;
(
    input  logic [3:0] code,
    input  logic       is_quick,
    input  logic       a2,
    output qdec_t      dec
);
    always_comb begin
        dec       = '0;
        dec.op    = OP_NONE;
        if (is_quick && !a2) begin
            dec.recog = 1'b1;
            case (qcode_e'(code))
                QC_NOP:       dec.is_nop = 1'b1;
                QC_RESTORE: begin
                    dec.op         = OP_LOAD;
                    dec.is_restore = 1'b1;
                end
                QC_STORE: begin
                    dec.op       = OP_SAVE;
                    dec.nv_write = 1'b1;
                end
                QC_HALVE_ONE: dec.op = OP_HALVE;
                QC_HALVE_ALL: begin dec.op = OP_HALVE; dec.bcast = 1'b1; end
                QC_DOWN_ONE:  dec.op = OP_DOWN;
                QC_DOWN_ALL:  begin dec.op = OP_DOWN;  dec.bcast = 1'b1; end
                QC_RELOAD: begin
                    dec.op       = OP_LOAD;
                    dec.bcast    = 1'b1;
                    dec.nv_write = 1'b1;
                end
                QC_DBL_ONE:   dec.op = OP_DBL;
                QC_DBL_ALL:   begin dec.op = OP_DBL;   dec.bcast = 1'b1; end
                QC_UP_ONE:    dec.op = OP_UP;
                QC_UP_ALL:    begin dec.op = OP_UP;    dec.bcast = 1'b1; end
                default:      dec.recog = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/digpot_wr_timer.sv
module digpot_wr_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/digpot_channel.sv
module digpot_channel
    import digpot_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned MID = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  chan_op_e     op,
    output logic [W-1:0] wiper,
    output logic [W-1:0] shadow
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] wiper_nx;

    always_comb begin
        wiper_nx = wiper;
        case (op)
            OP_LOAD:  wiper_nx = shadow;
            OP_HALVE: wiper_nx = wiper >> 1;
            OP_DOWN:  wiper_nx = (wiper == '0) ? '0 : wiper - 1'b1;
            OP_UP:    wiper_nx = (wiper == FULL) ? FULL : wiper + 1'b1;
            OP_DBL: begin
                if (wiper == '0)
                    wiper_nx = {{(W-1){1'b0}}, 1'b1};
                else if (wiper[W-1])
                    wiper_nx = FULL;
                else
                    wiper_nx = wiper << 1;
            end
            default:  wiper_nx = wiper;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= W'(MID);
            wiper  <= W'(MID);
        end else if (en) begin
            wiper <= wiper_nx;
            if (op == OP_SAVE)
                shadow <= wiper;
        end
    end
endmodule

// File: rtl/digpot_quick_ctrl.sv
module digpot_quick_ctrl
    import digpot_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned WIPER_W   = 8,
    parameter int unsigned MID       = 128,
    parameter int unsigned WR_CYCLES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic [3:0]                  cmd_code,
    input  logic [1:0]                  cmd_chan,
    input  logic                        cmd_is_quick,
    input  logic                        cmd_a2,
    input  logic                        wp_n,
    output logic                        busy,
    output logic                        read_pwr,
    output logic [NUM_CH*WIPER_W-1:0]   wiper_flat,
    output logic [NUM_CH*WIPER_W-1:0]   shadow_flat
);
    qdec_t dec;
    logic  accept;
    logic  apply;

    digpot_cmd_decode u_dec (
        .code     (cmd_code),
        .is_quick (cmd_is_quick),
        .a2       (cmd_a2),
        .dec      (dec)
    );

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign apply     = accept && dec.recog && wp_n;

    digpot_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (apply && dec.nv_write),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            read_pwr <= 1'b0;
        else if (accept && dec.recog && dec.is_restore)
            read_pwr <= 1'b1;
        else if (accept && dec.recog && dec.is_nop)
            read_pwr <= 1'b0;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = apply && (dec.bcast || (cmd_chan == 2'(i)));

        digpot_channel #(.W(WIPER_W), .MID(MID)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (hit),
            .op     (dec.op),
            .wiper  (wiper_flat[i*WIPER_W +: WIPER_W]),
            .shadow (shadow_flat[i*WIPER_W +: WIPER_W])
        );
    end
endmodule

// File: rtl/digpot_chk.sv
module digpot_chk #(
    parameter int unsigned FLAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [3:0]        cmd_code,
    input logic              cmd_is_quick,
    input logic              cmd_a2,
    input logic              wp_n,
    input logic              busy,
    input logic              read_pwr,
    input logic [FLAT_W-1:0] wiper_flat,
    input logic [FLAT_W-1:0] shadow_flat
);
    logic take;
    logic quick;
    assign take  = cmd_valid && cmd_ready;
    assign quick = cmd_is_quick && !cmd_a2;

    p_not_quick_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !quick) |=> ($stable(wiper_flat) && $stable(shadow_flat) && !busy));

    p_restore_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (take && quick && cmd_code == 4'd1) |=> read_pwr);

    p_nop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (take && quick && cmd_code == 4'd0) |=> !read_pwr);

    p_store_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (take && quick && wp_n && cmd_code == 4'd2) |=> busy);

    p_reload_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (take && quick && wp_n && cmd_code == 4'd7) |=> busy);

    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_code >= 4'd12) |=> ($stable(wiper_flat) && $stable(shadow_flat) && !busy));

    p_protect_r10: assert property (@(posedge clk) disable iff (rst)
        (take && !wp_n) |=> ($stable(wiper_flat) && $stable(shadow_flat) && !busy));

    p_busy_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(wiper_flat) && $stable(shadow_flat)));
endmodule

bind digpot_quick_ctrl digpot_chk #(.FLAT_W(NUM_CH*WIPER_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_code     (cmd_code),
    .cmd_is_quick (cmd_is_quick),
    .cmd_a2       (cmd_a2),
    .wp_n         (wp_n),
    .busy         (busy),
    .read_pwr     (read_pwr),
    .wiper_flat   (wiper_flat),
    .shadow_flat  (shadow_flat)
);

// File: tb/digpot_quick_ctrl_test.sv
module digpot_quick_ctrl_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NCH = 4;
    localparam int  WRC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_code = '0;
    logic [1:0]  cmd_chan = '0;
    logic        cmd_is_quick = 1'b1;
    logic        cmd_a2 = 1'b0;
    logic        wp_n = 1'b1;
    logic        busy;
    logic        read_pwr;
    logic [31:0] wiper_flat;
    logic [31:0] shadow_flat;

    int n_chk = 0;
    int n_bad = 0;
    int ew[NCH];
    int es[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    digpot_quick_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_chan(cmd_chan), .cmd_is_quick(cmd_is_quick),
        .cmd_a2(cmd_a2), .wp_n(wp_n), .busy(busy), .read_pwr(read_pwr),
        .wiper_flat(wiper_flat), .shadow_flat(shadow_flat)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NCH; i++) begin
            chk(req, $sformatf("wiper%0d", i), int'(wiper_flat[i*8 +: 8]), ew[i]);
            chk(req, $sformatf("shadow%0d", i), int'(shadow_flat[i*8 +: 8]), es[i]);
        end
    endtask

    function automatic int up1(input int v);  return (v == 255) ? 255 : v + 1; endfunction
    function automatic int dn1(input int v);  return (v == 0) ? 0 : v - 1; endfunction
    function automatic int dbl(input int v);  return (v == 0) ? 1 : ((v >= 128) ? 255 : v * 2); endfunction
    function automatic int hlv(input int v);  return v / 2; endfunction

    // Drive one command for a single rising edge; returns at the next falling edge.
    task automatic issue(input int code, input int ch, input logic quick = 1'b1, input logic a2 = 1'b0);
        cmd_code     = 4'(code);
        cmd_chan     = 2'(ch);
        cmd_is_quick = quick;
        cmd_a2       = a2;
        cmd_valid    = 1'b1;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NCH; i++) begin ew[i] = 128; es[i] = 128; end
        chk_regs("R1");
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "read_pwr", int'(read_pwr), 0);
        chk("R1", "cmd_ready", int'(cmd_ready), 1);
    endtask

    task automatic t_step();
        issue(10, 1); ew[1] = up1(ew[1]);
        issue(5, 2);  ew[2] = dn1(ew[2]);
        chk_regs("R6 R12");
        issue(8, 0);  ew[0] = dbl(ew[0]);   // 128 -> 255
        chk_regs("R7");
        issue(10, 0); ew[0] = up1(ew[0]);   // stays 255
        chk_regs("R6");
        for (int k = 0; k < 8; k++) begin issue(3, 3); ew[3] = hlv(ew[3]); end
        chk_regs("R7");                     // reaches 0
        issue(5, 3);  ew[3] = dn1(ew[3]);   // stays 0
        chk_regs("R6");
        issue(8, 3);  ew[3] = dbl(ew[3]);   // 0 -> 1
        issue(8, 3);  ew[3] = dbl(ew[3]);   // 1 -> 2
        chk_regs("R7");
    endtask

    task automatic t_bcast();
        issue(11, 2); for (int i = 0; i < NCH; i++) ew[i] = up1(ew[i]);
        chk_regs("R8");
        issue(6, 0);  for (int i = 0; i < NCH; i++) ew[i] = dn1(ew[i]);
        chk_regs("R8");
        issue(9, 1);  for (int i = 0; i < NCH; i++) ew[i] = dbl(ew[i]);
        chk_regs("R8");
        issue(4, 3);  for (int i = 0; i < NCH; i++) ew[i] = hlv(ew[i]);
        chk_regs("R8");
    endtask

    task automatic t_store();
        int n;
        issue(2, 0); es[0] = ew[0];
        chk_regs("R4");
        chk("R4", "cmd_ready", int'(cmd_ready), 0);
        wait_idle(n);
        chk("R4", "busy cycles", n, WRC);
        issue(10, 2); ew[2] = up1(ew[2]);
        issue(2, 2);  es[2] = ew[2];
        issue(10, 2);                       // refused while busy
        issue(0, 0);
        chk_regs("R11");
        chk("R11", "cmd_ready", int'(cmd_ready), 0);
        wait_idle(n);
        chk("R11", "busy ends", int'(busy), 0);
    endtask

    task automatic t_restore();
        issue(10, 0); ew[0] = up1(ew[0]);
        issue(1, 0);  ew[0] = es[0];
        chk_regs("R3");
        chk("R3", "read_pwr set", int'(read_pwr), 1);
        issue(10, 1); ew[1] = up1(ew[1]);
        chk("R3", "read_pwr held", int'(read_pwr), 1);
        issue(0, 0);
        chk("R3", "read_pwr cleared", int'(read_pwr), 0);
        chk_regs("R3");
    endtask

    task automatic t_reload();
        int n;
        issue(11, 0); for (int i = 0; i < NCH; i++) ew[i] = up1(ew[i]);
        issue(7, 1);  for (int i = 0; i < NCH; i++) ew[i] = es[i];
        chk_regs("R5");
        wait_idle(n);
        chk("R5", "busy cycles", n, WRC);
    endtask

    task automatic t_recog();
        issue(11, 0, 1'b0, 1'b0);
        chk_regs("R2 flag");
        issue(11, 0, 1'b1, 1'b1);
        issue(2, 1, 1'b1, 1'b1);
        chk_regs("R2 a2");
        chk("R2", "busy", int'(busy), 0);
    endtask

    task automatic t_reserved();
        for (int c = 12; c < 16; c++) issue(c, c % 4);
        chk_regs("R9");
        chk("R9", "busy", int'(busy), 0);
    endtask

    task automatic t_protect();
        wp_n = 1'b0;
        issue(11, 0);
        issue(2, 1);
        issue(7, 0);
        issue(8, 3);
        chk_regs("R10");
        chk("R10", "busy", int'(busy), 0);
        wp_n = 1'b1;
        issue(10, 3); ew[3] = up1(ew[3]);
        chk_regs("R10 released");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_step();
        t_bcast();
        t_store();
        t_restore();
        t_reload();
        t_recog();
        t_reserved();
        t_protect();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule